// File: doc/BRIEF.md
# Single-bit sector parity corrector

This block checks one 512-byte sector read from NAND flash against the 24-bit parity code that was saved with it. After the sector has streamed through a parity generator, the controller pulses `start` with two codes: the code read back from the spare area and the code just computed. The block then reports one of three outcomes: clean, corrected or uncorrectable. When exactly one data bit is wrong, it works out which byte and which bit are affected. It then repairs that bit in the sector buffer through a byte-wide read-modify-write port.

The split between outcomes depends on the difference word, which is the stored code XOR the computed code. The code keeps line parities in its upper twelve bits and their complements in its lower twelve bits. A lone data-bit flip therefore makes the two halves of the difference exact complements, and the upper half then carries the bit address. A difference with exactly one bit set means the flip is in the stored code, not in the data.

A separate combinational path turns a raw 32-bit parity register value into the 24-bit code that is stored in flash. It takes the two 12-bit halves and inverts the result, so an erased page with all parity bits at zero produces an all-ones code. That matches the erased spare area, and such a page checks clean.

Top module: `nand_ecc1_fix`

## Requirements
- R1: `packed_code` equals the bitwise inverse of {raw_parity[27:16], raw_parity[11:0]}. raw_parity bits 31:28 and 15:12 have no effect. `packed_code[7:0]` is the first byte stored in flash, `[15:8]` the second and `[23:16]` the third.
- R2: When stored_code equals calc_code, the block makes no buffer access. `done` is high in the cycle after the clock edge that samples `start`, and `status` reads 00 (clean).
- R3: A difference d is a correctable data error when d[23:12] XOR d[11:0] equals 12'hFFF. The byte index is d[23:15] and the bit index is d[14:12]. On completion `status` reads 01 (corrected), and `err_byte`/`err_bit` carry those indices.
- R4: A data fix reads the byte at the error index in the cycle after `start` is sampled. In the following cycle it writes the returned byte, with only the indexed bit inverted, back to the same address. `done` rises in the cycle after the write.
- R5: A correctable pattern whose byte index is not less than SECTOR_BYTES is reported as 10 (uncorrectable), and nothing is written.
- R6: A difference with exactly one set bit is reported as 01. The buffer is not accessed, and `err_byte` and `err_bit` read 0.
- R7: Any other nonzero difference is reported as 10. The buffer is not accessed.
- R8: `done` is a single-cycle pulse. `status`, `err_byte` and `err_bit` change only with `done` and hold their values between pulses. A `start` that arrives while a check is in progress is ignored.
- R9: While reset is asserted, `done`, `buf_rd_en` and `buf_wr_en` are 0, and `status`, `err_byte` and `err_bit` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_parity | input | 32 | Raw parity register value to be packed |
| packed_code | output | 24 | Inverted 24-bit code to store, low byte first |
| start | input | 1 | Begin a check when idle |
| stored_code | input | 24 | Code read back from flash |
| calc_code | input | 24 | Code computed over the sector just read |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| err_byte | output | 9 | Byte index of the repaired data bit |
| err_bit | output | 3 | Bit index of the repaired data bit |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read request, data returned next cycle |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_rdata | input | 8 | Buffer read data |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The bench targets the two extreme positions, byte 0 bit 0 and byte 511 bit 7. A design that mis-sliced the index would repair the wrong byte, and the sector image comparison would show it. It puts single flips at the lowest and highest code bits, where a design that tested the data pattern too loosely would write to the buffer. It tries a two-bit difference that is neither pattern, which must not be reported as corrected. A second instance with a smaller sector size is run at exactly the limit and one byte below it, to catch an off-by-one in the range test. A `start` issued while a repair is running must not produce an extra pulse or change the result. Packing is checked with only the ignored raw bits set, which must still give the all-ones erased code.

// File: rtl/ecc1_pkg.sv
package ecc1_pkg;
  typedef enum logic [1:0] {
    RES_CLEAN = 2'b00,
    RES_FIXED = 2'b01,
    RES_BAD   = 2'b10
  } ecc_res_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_EVAL,
    PH_READ,
    PH_WRITE
  } ecc_phase_e;
endpackage

// File: rtl/ecc1_pack.sv
module ecc1_pack #(
  parameter int HALF_W   = 12,
  parameter int RAW_W    = 32,
  parameter int HIGH_LSB = 16,
  localparam int CODE_W  = 2 * HALF_W
) (
  input  logic [RAW_W-1:0]  raw,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] joined;
  logic              unused_raw;

  assign joined     = {raw[HIGH_LSB +: HALF_W], raw[HALF_W-1:0]};
  assign code       = ~joined;
  assign unused_raw = ^{raw[RAW_W-1:HIGH_LSB+HALF_W], raw[HIGH_LSB-1:HALF_W]};
endmodule

// File: rtl/ecc1_classify.sv
module ecc1_classify
  import ecc1_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W      = 2 * HALF_W,
  localparam int BIT_W       = $clog2(DATA_W),
  localparam int IDX_W       = CODE_W - HALF_W - BIT_W
) (
  input  logic [CODE_W-1:0] diff,
  output ecc_res_e          res,
  output logic              need_fix,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BIT_W-1:0]  bit_idx
);
  localparam logic [IDX_W:0] LIMIT = SECTOR_BYTES[IDX_W:0];

  logic [HALF_W-1:0] fold;
  logic              is_zero;
  logic              is_data;
  logic              in_range;
  logic              is_single;

  always_comb begin
    fold      = diff[CODE_W-1:HALF_W] ^ diff[HALF_W-1:0];
    is_zero   = (diff == '0);
    is_data   = (fold == '1);
    byte_idx  = diff[CODE_W-1 -: IDX_W];
    bit_idx   = diff[HALF_W +: BIT_W];
    in_range  = ({1'b0, byte_idx} < LIMIT);
    is_single = $onehot(diff);
    need_fix  = 1'b0;
    if (is_zero) begin
      res = RES_CLEAN;
    end else if (is_data) begin
      res      = in_range ? RES_FIXED : RES_BAD;
      need_fix = in_range;
    end else if (is_single) begin
      res = RES_FIXED;
    end else begin
      res = RES_BAD;
    end
  end
endmodule

// File: rtl/ecc1_fix_fsm.sv
module ecc1_fix_fsm
  import ecc1_pkg::*;
#(
  parameter int CODE_W = 24,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] diff_in,
  output logic [CODE_W-1:0] diff_q,
  input  ecc_res_e          cls_res,
  input  logic              cls_fix,
  input  logic [IDX_W-1:0]  cls_byte,
  input  logic [BIT_W-1:0]  cls_bit,
  output logic              done,
  output ecc_res_e          status,
  output logic [IDX_W-1:0]  err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [IDX_W-1:0]  buf_addr,
  output logic              buf_rd_en,
  output logic              buf_wr_en,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [DATA_W-1:0] buf_wdata
);
  ecc_phase_e        phase_q, phase_d;
  logic              diff_en;
  logic              res_en;
  logic              done_d;
  ecc_res_e          status_d;
  logic [IDX_W-1:0]  byte_d;
  logic [BIT_W-1:0]  bit_d;
  logic [DATA_W-1:0] flip_mask;

  always_comb begin
    phase_d  = phase_q;
    diff_en  = 1'b0;
    res_en   = 1'b0;
    done_d   = 1'b0;
    status_d = status;
    byte_d   = err_byte;
    bit_d    = err_bit;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          diff_en = 1'b1;
          phase_d = PH_EVAL;
        end
      end
      PH_EVAL: begin
        if (cls_fix) begin
          phase_d = PH_READ;
        end else begin
          res_en   = 1'b1;
          done_d   = 1'b1;
          status_d = cls_res;
          byte_d   = '0;
          bit_d    = '0;
          phase_d  = PH_IDLE;
        end
      end
      PH_READ: phase_d = PH_WRITE;
      PH_WRITE: begin
        res_en   = 1'b1;
        done_d   = 1'b1;
        status_d = RES_FIXED;
        byte_d   = cls_byte;
        bit_d    = cls_bit;
        phase_d  = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      diff_q   <= '0;
      done     <= 1'b0;
      status   <= RES_CLEAN;
      err_byte <= '0;
      err_bit  <= '0;
    end else begin
      phase_q <= phase_d;
      done    <= done_d;
      if (diff_en) diff_q <= diff_in;
      if (res_en) begin
        status   <= status_d;
        err_byte <= byte_d;
        err_bit  <= bit_d;
      end
    end
  end

  assign flip_mask = DATA_W'(1) << cls_bit;
  assign buf_addr  = cls_byte;
  assign buf_rd_en = (phase_q == PH_READ);
  assign buf_wr_en = (phase_q == PH_WRITE);
  assign buf_wdata = buf_rdata ^ flip_mask;
endmodule

// File: rtl/nand_ecc1_fix.sv
module nand_ecc1_fix
  import ecc1_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int RAW_W        = 32,
  parameter int HIGH_LSB     = 16,
  parameter int DATA_W       = 8,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W      = 2 * HALF_W,
  localparam int BIT_W       = $clog2(DATA_W),
  localparam int ADDR_W      = CODE_W - HALF_W - BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW_W-1:0]  raw_parity,
  output logic [CODE_W-1:0] packed_code,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic              done,
  output logic [1:0]        status,
  output logic [ADDR_W-1:0] err_byte,
  output logic [BIT_W-1:0]  err_bit,
  output logic [ADDR_W-1:0] buf_addr,
  output logic              buf_rd_en,
  output logic              buf_wr_en,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic [DATA_W-1:0] buf_wdata
);
  logic [CODE_W-1:0] diff_in;
  logic [CODE_W-1:0] diff_q;
  ecc_res_e          cls_res;
  logic              cls_fix;
  logic [ADDR_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;
  ecc_res_e          status_e;

  assign diff_in = stored_code ^ calc_code;
  assign status  = status_e;

  ecc1_pack #(.HALF_W(HALF_W), .RAW_W(RAW_W), .HIGH_LSB(HIGH_LSB)) u_pack (
    .raw  (raw_parity),
    .code (packed_code)
  );

  ecc1_classify #(.HALF_W(HALF_W), .DATA_W(DATA_W), .SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .diff     (diff_q),
    .res      (cls_res),
    .need_fix (cls_fix),
    .byte_idx (cls_byte),
    .bit_idx  (cls_bit)
  );

  ecc1_fix_fsm #(.CODE_W(CODE_W), .DATA_W(DATA_W), .IDX_W(ADDR_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .diff_in   (diff_in),
    .diff_q    (diff_q),
    .cls_res   (cls_res),
    .cls_fix   (cls_fix),
    .cls_byte  (cls_byte),
    .cls_bit   (cls_bit),
    .done      (done),
    .status    (status_e),
    .err_byte  (err_byte),
    .err_bit   (err_bit),
    .buf_addr  (buf_addr),
    .buf_rd_en (buf_rd_en),
    .buf_wr_en (buf_wr_en),
    .buf_rdata (buf_rdata),
    .buf_wdata (buf_wdata)
  );
endmodule

// File: rtl/ecc1_chk.sv
module ecc1_chk #(
  parameter int ADDR_W = 9,
  parameter int BIT_W  = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [1:0]        status,
  input logic [ADDR_W-1:0] err_byte,
  input logic [BIT_W-1:0]  err_bit,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_rd_en,
  input logic              buf_wr_en,
  input logic [DATA_W-1:0] buf_rdata,
  input logic [DATA_W-1:0] buf_wdata
);
  p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en) && (buf_addr == $past(buf_addr))));

  p_flip_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));

  p_no_rw_clash_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd_en && buf_wr_en));

  p_done_after_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> (done && status == 2'b01));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

  p_legal_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
endmodule

bind nand_ecc1_fix ecc1_chk #(.ADDR_W(ADDR_W), .BIT_W(BIT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .status    (status),
  .err_byte  (err_byte),
  .err_bit   (err_bit),
  .buf_addr  (buf_addr),
  .buf_rd_en (buf_rd_en),
  .buf_wr_en (buf_wr_en),
  .buf_rdata (buf_rdata),
  .buf_wdata (buf_wdata)
);

// File: tb/sim_nand_ecc1_fix.sv
module sim_nand_ecc1_fix;
  logic        clk;
  logic        rst_n;
  logic [31:0] raw_parity;
  logic [23:0] packed_code;
  logic        start;
  logic [23:0] stored_code, calc_code;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  err_byte, buf_addr;
  logic [2:0]  err_bit;
  logic        buf_rd_en, buf_wr_en;
  logic [7:0]  buf_rdata, buf_wdata;

  logic        u1_start;
  logic [23:0] u1_calc;
  logic [23:0] u1_packed;
  logic        u1_done, u1_rd, u1_wr;
  logic [1:0]  u1_status;
  logic [8:0]  u1_eb, u1_addr;
  logic [2:0]  u1_ebit;
  logic [7:0]  u1_wdata;
  logic        u1_wr_seen;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mem [0:511];
  logic [7:0] ref_mem [0:511];

  initial clk = 0;
  always #2 clk = ~clk;

  nand_ecc1_fix u0 (
    .clk(clk), .rst_n(rst_n), .raw_parity(raw_parity), .packed_code(packed_code),
    .start(start), .stored_code(stored_code), .calc_code(calc_code),
    .done(done), .status(status), .err_byte(err_byte), .err_bit(err_bit),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
    .buf_rdata(buf_rdata), .buf_wdata(buf_wdata)
  );

  nand_ecc1_fix #(.SECTOR_BYTES(320)) u1 (
    .clk(clk), .rst_n(rst_n), .raw_parity(raw_parity), .packed_code(u1_packed),
    .start(u1_start), .stored_code(stored_code), .calc_code(u1_calc),
    .done(u1_done), .status(u1_status), .err_byte(u1_eb), .err_bit(u1_ebit),
    .buf_addr(u1_addr), .buf_rd_en(u1_rd), .buf_wr_en(u1_wr),
    .buf_rdata(8'h00), .buf_wdata(u1_wdata)
  );

  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) mem[buf_addr] <= buf_wdata;
    if (u1_wr) u1_wr_seen <= 1'b1;
  end

  // behavioural reference model, advanced on each rising edge
  bit        m_busy, m_done, p_fix;
  int        m_cnt, m_status, m_byte, m_bit, p_status, p_byte, p_bit;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0;
      m_status = 0; m_byte = 0; m_bit = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_status = p_status; m_byte = p_byte; m_bit = p_bit;
          if (p_fix) ref_mem[p_byte] = ref_mem[p_byte] ^ 8'(1 << p_bit);
        end
      end else if (start) begin
        int d;
        d = int'(stored_code ^ calc_code);
        p_fix = 0; p_byte = 0; p_bit = 0;
        if (d == 0) p_status = 0;
        else if ((((d >> 12) ^ d) & 'hFFF) == 'hFFF) begin
          if ((d >> 15) < 512) begin
            p_status = 1; p_fix = 1; p_byte = d >> 15; p_bit = (d >> 12) & 7;
          end else p_status = 2;
        end else if ((d & (d - 1)) == 0) p_status = 1;
        else p_status = 2;
        m_busy = 1;
        m_cnt = p_fix ? 3 : 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 pulse and hold)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 done", int'(done), int'(m_done));
      chk("R8 status", int'(status), m_status);
      chk("R3 err_byte", int'(err_byte), m_byte);
      chk("R3 err_bit", int'(err_bit), m_bit);
    end
  end

  function automatic logic [23:0] syn(input int b, input int k);
    logic [11:0] hi;
    hi = 12'(b * 8 + k);
    return {hi, ~hi};
  endfunction

  task automatic check_image(input string req);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic run(input string req, input logic [23:0] s, input logic [23:0] c, input int exp);
    @(negedge clk);
    stored_code = s; calc_code = c; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    chk(req, int'(status), exp);
    check_image(req);
  endtask

  task automatic run_u1(input string req, input logic [23:0] c, input int exp, input int exp_wr);
    @(negedge clk);
    u1_wr_seen = 0; stored_code = 24'h0; u1_calc = c; u1_start = 1;
    @(negedge clk);
    u1_start = 0;
    repeat (5) @(negedge clk);
    chk(req, int'(u1_status), exp);
    chk(req, int'(u1_wr_seen), exp_wr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 8'((i * 37) ^ 8'h5A);
      ref_mem[i] = mem[i];
    end
    rst_n = 0; start = 0; u1_start = 0; u1_wr_seen = 0;
    stored_code = 0; calc_code = 0; u1_calc = 0; raw_parity = 0;
    repeat (3) @(negedge clk);
    chk("R9 done", int'(done), 0);
    chk("R9 status", int'(status), 0);
    chk("R9 rd", int'(buf_rd_en), 0);
    chk("R9 wr", int'(buf_wr_en), 0);
    chk("R9 err", int'({err_byte, err_bit}), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);

    raw_parity = 32'h0000_0000; #1 chk("R1 erased", int'(packed_code), 'hFFFFFF);
    raw_parity = 32'hF000_F000; #1 chk("R1 ignored bits", int'(packed_code), 'hFFFFFF);
    raw_parity = 32'h0ABC_0123; #1 chk("R1 halves", int'(packed_code), 'h543EDC);
    chk("R1 first byte", int'(packed_code[7:0]), 'hDC);
    chk("R1 third byte", int'(packed_code[23:16]), 'h54);

    run("R2 clean", 24'h123456, 24'h123456, 0);
    run("R2 erased clean", 24'hFFFFFF, 24'hFFFFFF, 0);
    run("R3 byte0 bit0", 24'h0F0F0F, 24'h0F0F0F ^ syn(0, 0), 1);
    run("R4 byte511 bit7", 24'hA5A5A5, 24'hA5A5A5 ^ syn(511, 7), 1);
    run("R3 byte300 bit3", 24'h000000, syn(300, 3), 1);
    run("R6 low code bit", 24'h111111, 24'h111110, 1);
    run("R6 high code bit", 24'h000000, 24'h800000, 1);
    run("R7 two bits", 24'h000000, 24'h000003, 2);
    run("R7 near pattern", 24'h000000, syn(10, 2) ^ 24'h000001, 2);

    // start pulsed again while a fix is in progress (R8)
    @(negedge clk);
    stored_code = 0; calc_code = syn(42, 5); start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); calc_code = 24'h000003; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    chk("R8 busy start ignored", int'(status), 1);
    chk("R8 busy err_byte", int'(err_byte), 42);
    check_image("R8 busy image");

    run_u1("R5 at limit", syn(320, 1), 2, 0);
    run_u1("R5 above limit", syn(400, 6), 2, 0);
    run_u1("R5 below limit", syn(319, 4), 1, 1);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule